// File: doc/BRIEF.md
# Programmable Divider Toggle Timer

This block is an 8-bit up-counting timer running in divider-output mode. A free-running prescaler divides the system clock and produces a one-cycle enable at a rate chosen by a clock-select field. The counter advances only on that enable. When the incremented count equals the compare register, the counter returns to zero, a toggle flip-flop flips, and a single-cycle interrupt pulse is raised. Because the counter keeps running after each match, the flip-flop produces a square wave near 50% duty. Each half-period lasts the compare value times the prescaler division.

The output pin carries the inverted flip-flop level, and only while the port latch input is 1. While the latch is 0 the pin is held low. The flip-flop is cleared by reset and whenever the timer stops. Stopping while the pin is low therefore cuts that low phase short.

The control word is 6 bits. Bits [1:0] are the mode field, and 2'b10 selects divider output. Bits [4:2] are the clock select. Bit 5 is the run bit.

Top module: `pdo_timer`

## Requirements
- R1: Clock select 3'b000 divides the system clock by 2^LOG2_SEL0 (default 1024). 3'b001 divides by 2^LOG2_SEL1 (default 128). 3'b010 divides by 2^LOG2_SEL2 (default 8). Any value from 3'b011 to 3'b111 divides by 2^LOG2_SEL3 (default 2). Clock select occupies control bits [4:2].
- R2: While running, consecutive interrupt pulses are exactly compare × division system cycles apart.
- R3: The interrupt is a pulse one system cycle wide, asserted combinationally in the cycle in which the match is detected.
- R4: The toggle flip-flop inverts once per match. The pin shows its inverse while the port latch is 1, so the pin level alternates between consecutive interrupts.
- R5: While the port latch is 0, the pin is 0.
- R6: After reset the flip-flop is 0 and the interrupt is low, so the pin equals the port latch.
- R7: Clearing the run bit (control bit 5) clears the counter and the flip-flop at the next clock edge. No interrupt occurs while the timer is stopped.
- R8: A mode field (control bits [1:0]) other than 2'b10 behaves as stopped, even when the run bit is set.
- R9: A compare value of 0 gives 256 counts per half-period.
- R10: A compare value written while running is used from the next comparison.
- R11: After the run bit is set, counting restarts from zero. The first interrupt arrives no later than (compare+1) × division system cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control word: run[5], clock select[4:2], mode[1:0] |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare value (0 means 2^CNT_W) |
| port_latch | input | 1 | Port output latch bit that enables the pin |
| irq | output | 1 | Match interrupt pulse |
| pdo_pin | output | 1 | Divider output, inverted flip-flop gated by the latch |

## Verification
The bench builds the timer with the division exponents set to 4, 3, 2 and 1, so the four clock selects divide by 16, 8, 4 and 2. At these rates every select, a compare of 1 (an interrupt every second cycle) and the 256-count case with compare 0 all fit into a few hundred cycles each. This lets every period be measured exactly, edge to edge. The counter width keeps its default of 8, so the wrap from 255 to 0 that implements compare 0 is the real one.

// File: rtl/pdo_timer_pkg.sv
package pdo_timer_pkg;

    localparam int unsigned CTRL_W = 6;
    localparam logic [1:0] MODE_DIVOUT = 2'b10;

    typedef struct packed {
        logic       run;
        logic [2:0] clk_sel;
        logic [1:0] mode;
    } ctrl_t;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pdo_prescaler.sv
module pdo_prescaler
    import pdo_timer_pkg::*;
#(
    parameter int unsigned LOG2_SEL0 = 10,
    parameter int unsigned LOG2_SEL1 = 7,
    parameter int unsigned LOG2_SEL2 = 3,
    parameter int unsigned LOG2_SEL3 = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);

    localparam int unsigned LOG2_TAB [4] = '{LOG2_SEL0, LOG2_SEL1, LOG2_SEL2, LOG2_SEL3};
    localparam int unsigned PRE_W = max4(LOG2_SEL0, LOG2_SEL1, LOG2_SEL2, LOG2_SEL3);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [3:0]       tap;
    logic [1:0]       sel_idx;

    for (genvar i = 0; i < 4; i++) begin : g_tap
        assign tap[i] = &pre_q[LOG2_TAB[i]-1:0];
    end

    always_comb begin
        pre_d = pre_q + 1'b1;
        case (clk_sel)
            3'b000:  sel_idx = 2'd0;
            3'b001:  sel_idx = 2'd1;
            3'b010:  sel_idx = 2'd2;
            default: sel_idx = 2'd3;
        endcase
        tick = tap[sel_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/pdo_core.sv
module pdo_core #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             match,
    output logic             flip
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             ff;
    } core_t;

    core_t            st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        match   = 1'b0;
        cnt_inc = st_q.cnt + 1'b1;
        if (cmp_we) st_d.cmp = cmp_wdata;
        if (!active) begin
            st_d.cnt = '0;
            st_d.ff  = 1'b0;
        end else if (tick) begin
            if (cnt_inc == st_q.cmp) begin
                match    = 1'b1;
                st_d.cnt = '0;
                st_d.ff  = ~st_q.ff;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flip = st_q.ff;

    // R3
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);

    // R4
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (st_q.ff != $past(st_q.ff)));

    // R7
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.ff == 1'b0 && st_q.cnt == '0));

    // R7
    no_irq_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !match);

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(st_q.cnt));

endmodule

// File: rtl/pdo_timer.sv
module pdo_timer
    import pdo_timer_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned LOG2_SEL0 = 10,
    parameter int unsigned LOG2_SEL1 = 7,
    parameter int unsigned LOG2_SEL2 = 3,
    parameter int unsigned LOG2_SEL3 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              cmp_we,
    input  logic [CNT_W-1:0]  cmp_wdata,
    input  logic              port_latch,
    output logic              irq,
    output logic              pdo_pin
);

    ctrl_t ctrl_d, ctrl_q;
    logic  active;
    logic  tick;
    logic  flip;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) ctrl_d = ctrl_t'(ctrl_wdata);
        active = ctrl_q.run && (ctrl_q.mode == MODE_DIVOUT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    pdo_prescaler #(
        .LOG2_SEL0 (LOG2_SEL0),
        .LOG2_SEL1 (LOG2_SEL1),
        .LOG2_SEL2 (LOG2_SEL2),
        .LOG2_SEL3 (LOG2_SEL3)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (ctrl_q.clk_sel),
        .tick    (tick)
    );

    pdo_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .match     (irq),
        .flip      (flip)
    );

    assign pdo_pin = port_latch & ~flip;

    // R5
    latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_latch |-> !pdo_pin);

    // R8
    wrong_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode != MODE_DIVOUT) |-> !irq);

endmodule

// File: tb/pdo_timer_test.sv
module pdo_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [5:0] ctrl_wdata = '0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic       port_latch = 1'b1;
    logic       irq;
    logic       pdo_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pdo_timer #(
        .CNT_W(8), .LOG2_SEL0(4), .LOG2_SEL1(3), .LOG2_SEL2(2), .LOG2_SEL3(1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .port_latch(port_latch),
        .irq(irq), .pdo_pin(pdo_pin)
    );

    // clk_sel[23:21], compare[20:13], expected interrupt period[12:0]
    localparam logic [23:0] VEC [6] = '{
        {3'd0, 8'd5, 13'd80},
        {3'd1, 8'd7, 13'd56},
        {3'd2, 8'd3, 13'd12},
        {3'd5, 8'd9, 13'd18},
        {3'd7, 8'd1, 13'd2},
        {3'd3, 8'd0, 13'd512}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic run, input logic [2:0] sel, input logic [1:0] mode);
        ctrl_we = 1'b1; ctrl_wdata = {run, sel, mode};
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic next_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 5000);
    endtask

    task automatic quiet(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (irq) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, first;
        logic p0;
        logic [2:0] sel;
        logic [7:0] cv;
        int per;

        repeat (3) @(negedge clk);
        // R6 reset state
        check(irq == 1'b0, "R6 irq", irq, 0);
        check(pdo_pin == 1'b1, "R6 pin", pdo_pin, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(pdo_pin == 1'b1, "R6 pin after release", pdo_pin, 1);

        // R1 R2 R4 R9 R11 table walk
        for (int v = 0; v < 6; v++) begin
            sel = VEC[v][23:21];
            cv  = VEC[v][20:13];
            per = int'(VEC[v][12:0]);
            wr_ctrl(1'b0, sel, 2'b10);
            wr_cmp(cv);
            wr_ctrl(1'b1, sel, 2'b10);
            next_irq(first);
            check(first <= per + per / ((cv == 0) ? 256 : int'(cv)), "R11 first match", first, per);
            p0 = pdo_pin;
            next_irq(n);
            check(n == per, (cv == 0) ? "R9 period" : "R1 R2 period", n, per);
            check(pdo_pin == ~p0, "R4 pin alternates", pdo_pin, ~p0);
            p0 = pdo_pin;
            next_irq(n);
            check(n == per, "R2 period again", n, per);
            check(pdo_pin == ~p0, "R4 pin alternates again", pdo_pin, ~p0);
            if (per > 1) begin
                @(negedge clk);
                check(irq == 1'b0, "R3 one-cycle irq", irq, 0);
            end
        end

        // R10 compare rewrite while running (divide by 2)
        wr_ctrl(1'b0, 3'd7, 2'b10);
        wr_cmp(8'd10);
        wr_ctrl(1'b1, 3'd7, 2'b10);
        next_irq(first);
        next_irq(n);
        check(n == 20, "R10 old compare", n, 20);
        wr_cmp(8'd3);
        next_irq(n);
        check(n == 5, "R10 new compare", n + 1, 6);

        // R7 stop while flip-flop is 1 (pin low)
        next_irq(n);
        @(negedge clk);
        if (pdo_pin == 1'b1) begin
            next_irq(n);
            @(negedge clk);
        end
        check(pdo_pin == 1'b0, "R7 pin low before stop", pdo_pin, 0);
        wr_ctrl(1'b0, 3'd7, 2'b10);
        @(negedge clk);
        check(pdo_pin == 1'b1, "R7 stop clears flip-flop", pdo_pin, 1);
        quiet(100, "R7 no irq when stopped");

        // R5 latch gating
        port_latch = 1'b0;
        wr_ctrl(1'b1, 3'd7, 2'b10);
        begin
            int hi = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (pdo_pin) hi++;
            end
            check(hi == 0, "R5 pin held low", hi, 0);
        end
        port_latch = 1'b1;

        // R8 wrong mode with run set
        wr_ctrl(1'b1, 3'd7, 2'b01);
        @(negedge clk);
        check(pdo_pin == 1'b1, "R8 flip-flop cleared", pdo_pin, 1);
        quiet(60, "R8 no irq in other mode");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule